// File: doc/BRIEF.md
# Two-Wire Serial Byte-Store Target

This block is a target (slave) on a two-wire serial bus that fronts a small byte-wide storage array. Both bus lines are brought into the system clock domain through synchronisers. Start and stop conditions are found by comparing the current and previous samples of the data line while the clock line is high. The block answers one fixed 7-bit device address. The lowest bit of the first byte selects a write or a read. The data line is modelled as an open-drain output: `sda_oe` high means the block pulls the line low.

A write carries one word-address byte, which loads an internal pointer. It may carry one data byte after that. When a stop condition closes a write whose data byte was acknowledged, the byte is committed to the array at the pointer. The block then stays off the bus for a fixed number of system clocks, which models a programming interval. A read streams bytes from the pointer for as long as the controller acknowledges each one. When the controller withholds its acknowledge, the block releases the line and waits for the next start or stop condition.

Top module: `serial_mem_target`

## Requirements
- R1: The first byte after a start condition is the device address, sent MSB first. Bits 7..1 must equal `DEV_ADDR` (default 7'b1010000) for the block to answer. Bit 0 is the direction: 0 means write and 1 means read. The block does not acknowledge any other address.
- R2: To acknowledge a byte, the block holds the data line low for the whole high phase of the ninth clock pulse. It releases the line at the next falling edge of the clock.
- R3: In a write, the block acknowledges the address byte, the word-address byte and one data byte. It does not acknowledge a fourth byte.
- R4: The word-address byte, taken modulo `DEPTH`, loads the pointer. The data byte is stored at the pointer when the closing stop condition arrives. The pointer then advances by one and wraps from `DEPTH`-1 to 0.
- R5: A stop condition that follows an acknowledged data byte starts a programming interval of `PROG_CYCLES` system clocks. A stop condition after a write that carried no data byte starts no interval.
- R6: During the programming interval the block never drives the data line, not even to acknowledge its own address. Once the interval has ended it answers again.
- R7: A read sends the byte at the pointer first, MSB first, and advances the pointer after each byte sent, wrapping at `DEPTH`. The block sends the next byte only if it samples the acknowledge slot low.
- R8: If the controller leaves the acknowledge slot high during a read, the block releases the data line. It drives nothing more until the next start or stop condition.
- R9: A read with no word address before it continues from the pointer left by the last access.
- R10: Input bits are sampled on the rising edge of the clock line. The block changes its data-line output only while the clock line is low, except for the release that a start or stop condition forces.
- R11: A start condition is recognised in any state, including in the middle of a byte. It restarts the bit count, so the next byte is taken as a device address.
- R12: After reset the data line is released, every array byte is zero and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest case to reach is an address byte that arrives while a programming interval is running. The stimulus gets there by opening a new transfer right after the stop condition of a byte write and checking that the ninth pulse shows no acknowledge. It then waits out `PROG_CYCLES` and repeats the address byte, which must now be acknowledged. Reads are arranged to cross the top of the array so that pointer wrap-around shows at the port. A start condition is also placed partway through a byte, and the transfer after it must behave as a fresh one. Randomly chosen addresses and data, from a fixed seed, are compared against a bench model of the array.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TXACK,
        ST_TXNEXT,
        ST_WAIT
    } bus_st_e;

    typedef enum logic [1:0] {
        RL_DEV,
        RL_WORD,
        RL_DATA
    } byte_role_e;

endpackage

// File: rtl/smt_sync_edge.sv
module smt_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic lvl_prev
);
    // STAGES flops of synchronisation plus one flop holding the previous level
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-1:0], din};
    end

    assign lvl      = chain_q[STAGES-1];
    assign lvl_prev = chain_q[STAGES];
endmodule

// File: rtl/smt_prog_timer.sv
module smt_prog_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (kick)              cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/smt_store.sv
module smt_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int          DEPTH       = 16,
    parameter int          PROG_CYCLES = 1000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    import serial_mem_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        bus_st_e    st;
        byte_role_e role;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic       rw;
        logic [PW-1:0] ptr;
        logic [7:0] data;
        logic       pend;
        logic       oe;
    } ctl_t;

    ctl_t d, q;

    logic scl_s, scl_p, sda_s, sda_p;
    logic start_c, stop_c, rise_c, fall_c;
    logic prog_kick, busy;
    logic [7:0] rd_byte;

    smt_sync_edge #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_in), .lvl(scl_s), .lvl_prev(scl_p)
    );
    smt_sync_edge #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .lvl(sda_s), .lvl_prev(sda_p)
    );
    smt_prog_timer #(.CYCLES(PROG_CYCLES)) u_prog (
        .clk(clk), .rst_n(rst_n), .kick(prog_kick), .busy(busy)
    );
    smt_store #(.DEPTH(DEPTH), .AW(PW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(prog_kick), .waddr(q.ptr),
        .wdata(q.data), .raddr(q.ptr), .rdata(rd_byte)
    );

    assign start_c = scl_s && scl_p && sda_p && !sda_s;
    assign stop_c  = scl_s && scl_p && !sda_p && sda_s;
    assign rise_c  = scl_s && !scl_p;
    assign fall_c  = !scl_s && scl_p;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d         = q;
        prog_kick = 1'b0;
        if (busy) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (start_c) begin
            d.st   = ST_RX;
            d.role = RL_DEV;
            d.cnt  = '0;
            d.oe   = 1'b0;
            d.pend = 1'b0;
        end else if (stop_c) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
            if (q.pend) begin
                prog_kick = 1'b1;
                d.pend    = 1'b0;
                d.ptr     = ptr_inc(q.ptr);
            end
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (rise_c) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_c && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        d.oe  = 1'b1;
                        unique case (q.role)
                            RL_DEV: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    d.rw = q.sh[0];
                                end else begin
                                    d.st = ST_WAIT;
                                    d.oe = 1'b0;
                                end
                            end
                            RL_WORD: d.ptr = PW'(32'(q.sh) % DEPTH);
                            RL_DATA: begin
                                d.data = q.sh;
                                d.pend = 1'b1;
                            end
                            default: begin
                                d.st = ST_WAIT;
                                d.oe = 1'b0;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall_c) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        if (q.role == RL_DEV && q.rw) begin
                            d.st  = ST_TX;
                            d.sh  = rd_byte;
                            d.oe  = !rd_byte[7];
                            d.ptr = ptr_inc(q.ptr);
                        end else if (q.role == RL_DEV) begin
                            d.st   = ST_RX;
                            d.role = RL_WORD;
                        end else if (q.role == RL_WORD) begin
                            d.st   = ST_RX;
                            d.role = RL_DATA;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                ST_TX: begin
                    if (rise_c) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_c) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_TXACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = !q.sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (rise_c) d.st = sda_s ? ST_WAIT : ST_TXNEXT;
                end
                ST_TXNEXT: begin
                    if (fall_c) begin
                        d.st  = ST_TX;
                        d.cnt = '0;
                        d.sh  = rd_byte;
                        d.oe  = !rd_byte[7];
                        d.ptr = ptr_inc(q.ptr);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.role <= RL_DEV;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
endmodule

// File: rtl/smt_checker.sv
module smt_checker #(
    parameter int PW    = 4,
    parameter int DEPTH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_lvl,
    input logic          bus_evt,
    input logic          sda_oe,
    input logic          busy,
    input logic          kick,
    input logic          wait_st,
    input logic [PW-1:0] ptr
);
    // R10: the output moves only with the clock line low, or on a start/stop release
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_lvl) || $past(bus_evt)));

    // R6: line is never driven during the programming interval
    assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R5: an interval begins only on a commit
    assert_prog_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(kick));

    // R5: a commit always opens an interval
    assert_prog_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> busy);

    // R8: after a withheld acknowledge the line stays released
    assert_wait_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_st |-> !sda_oe);

    // R4: the pointer steps by one with wrap after a commit
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (ptr == (($past(ptr) == PW'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1)));
endmodule

bind serial_mem_target smt_checker #(.PW(PW), .DEPTH(DEPTH)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .scl_lvl(scl_s),
    .bus_evt(start_c | stop_c),
    .sda_oe(sda_oe),
    .busy(busy),
    .kick(prog_kick),
    .wait_st(q.st == serial_mem_pkg::ST_WAIT),
    .ptr(q.ptr)
);

// File: tb/serial_mem_target_bench.sv
module serial_mem_target_bench;
    localparam int DEPTH = 16;
    localparam int PROG  = 1000;
    localparam int Q     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_mem [DEPTH];
    int m_ptr = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    serial_mem_target #(.DEPTH(DEPTH), .PROG_CYCLES(PROG)) u_serial_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic s_mid, output logic s_late);
        sda_m = b;
        hq();
        scl = 1'b1;
        hq();
        s_mid = sda_line;
        hq();
        s_late = sda_line;
        scl = 1'b0;
        hq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hq();
        scl = 1'b1;   hq();
        sda_m = 1'b0; hq();
        scl = 1'b0;   hq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hq();
        scl = 1'b1;   hq();
        sda_m = 1'b1; hq();
    endtask

    // returns 1 when the target acknowledged over the whole ninth high phase (R2)
    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s1, s2);
        clk_bit(1'b1, s1, s2);
        acked = !s1 && !s2;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] b);
        logic s1, s2, x1, x2;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s1, s2);
            b[i] = s1;
            chk("R10 bit stable while clock high", int'(s2), int'(s1));
        end
        clk_bit(!m_ack, x1, x2);
        sda_m = 1'b1;
    endtask

    function automatic int wrap(input int p);
        return (p + 1) % DEPTH;
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [7:0] dat);
        logic ak;
        bus_start();
        send_byte(8'hA0, ak); chk("R1 write address ack", int'(ak), 1);
        send_byte(a, ak);     chk("R3 word address ack", int'(ak), 1);
        send_byte(dat, ak);   chk("R3 data ack (R2)", int'(ak), 1);
        bus_stop();
        m_mem[a % DEPTH] = dat;
        m_ptr = wrap(a % DEPTH);
    endtask

    task automatic wait_prog();
        repeat (PROG + 100) @(negedge clk);
    endtask

    task automatic do_read(input bit set_addr, input logic [7:0] a, input int n);
        logic ak, s1, s2;
        logic [7:0] got;
        bus_start();
        if (set_addr) begin
            send_byte(8'hA0, ak); chk("R4 pointer-set address ack", int'(ak), 1);
            send_byte(a, ak);     chk("R4 pointer-set word ack", int'(ak), 1);
            m_ptr = a % DEPTH;
            bus_start();
        end
        send_byte(8'hA1, ak); chk("R1 read address ack", int'(ak), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, got);
            chk(set_addr ? "R7 read data" : "R9 current read data",
                int'(got), int'(m_mem[m_ptr]));
            m_ptr = wrap(m_ptr);
        end
        clk_bit(1'b1, s1, s2);
        chk("R8 released after withheld ack", int'(s1 & s2), 1);
        bus_stop();
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic ak, s1, s2;
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk("R12 released during reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R12 released after reset", int'(sda_oe), 0);

        // R12/R9: current read from reset comes from location 0
        do_read(1'b0, 8'h00, 2);

        // R5/R6: write, then knock during the programming interval
        do_write(8'h05, 8'h3C);
        bus_start();
        send_byte(8'hA0, ak);
        chk("R6 no ack while programming", int'(ak), 0);
        bus_stop();
        wait_prog();
        do_read(1'b1, 8'h05, 3);

        // R7/R4: wrap across the top of the array
        do_write(8'h0F, 8'h81); wait_prog();
        do_write(8'h00, 8'h7E); wait_prog();
        do_write(8'h1E, 8'h42); wait_prog();   // word address reduced modulo DEPTH
        do_read(1'b1, 8'h0E, 4);
        do_read(1'b0, 8'h00, 1);               // R9 continues from pointer

        // R1: other device addresses are ignored
        bus_start();
        send_byte(8'hA2, ak); chk("R1 wrong address no ack", int'(ak), 0);
        bus_stop();
        bus_start();
        send_byte(8'h21, ak); chk("R1 wrong address no ack", int'(ak), 0);
        bus_stop();

        // R3: a fourth byte is not acknowledged; the data byte still commits
        do_write(8'h09, 8'hC5);   // repeated below with extra byte; model same
        wait_prog();
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h0A, ak);
        send_byte(8'h5A, ak);
        send_byte(8'hFF, ak); chk("R3 fourth byte no ack", int'(ak), 0);
        bus_stop();
        m_mem[10] = 8'h5A; m_ptr = 11;
        wait_prog();
        do_read(1'b1, 8'h09, 2);

        // R5: stop without data starts no interval; R4 pointer loaded
        bus_start();
        send_byte(8'hA0, ak);
        send_byte(8'h05, ak);
        bus_stop();
        m_ptr = 5;
        bus_start();
        send_byte(8'hA1, ak); chk("R5 no interval without data", int'(ak), 1);
        recv_byte(1'b0, m_mem[15]);   // placeholder target, restored below
        m_mem[15] = 8'h81;
        m_ptr = 6;
        bus_stop();
        do_read(1'b0, 8'h00, 1);

        // R11: start in the middle of a byte restarts the count
        bus_start();
        clk_bit(1'b1, s1, s2);
        clk_bit(1'b0, s1, s2);
        clk_bit(1'b1, s1, s2);
        bus_start();
        send_byte(8'hA0, ak); chk("R11 address after mid-byte start", int'(ak), 1);
        send_byte(8'h03, ak); chk("R11 word after mid-byte start", int'(ak), 1);
        send_byte(8'h99, ak); chk("R11 data after mid-byte start", int'(ak), 1);
        bus_stop();
        m_mem[3] = 8'h99; m_ptr = 4;
        wait_prog();
        do_read(1'b1, 8'h03, 1);

        // random writes and reads against the model (R4, R7)
        for (int t = 0; t < 12; t++) begin
            logic [7:0] ra, rd;
            ra = 8'($urandom_range(0, 255));
            rd = 8'($urandom);
            do_write(ra, rd);
            wait_prog();
        end
        for (int t = 0; t < 8; t++) begin
            do_read(1'b1, 8'($urandom_range(0, DEPTH - 1)), int'($urandom_range(1, 4)));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule